// File: doc/BRIEF.md
# SPI-attached UART host sequencer

This block is a host-side engine that talks to an external UART bridge over a 16-bit SPI link and presents a plain byte stream to the rest of the chip. Every exchange is a single 16-bit frame. The top two bits of the outgoing word select the operation: 11 writes the configuration, 01 reads it back, 10 writes a data byte and 00 reads a data byte. In every response, bit 15 flags a received byte and bit 14 flags an empty transmit buffer.

After reset the engine programs the bridge configuration with a baud code taken from a rate selector. It checks the setting by reading it back and retries after a gap until the two agree or a try limit is reached. After that it serves two jobs:

- To transmit a byte, it polls the configuration until the bridge reports room, then writes the byte. A line feed is sent as carriage return followed by line feed.
- When no byte is waiting to go out, it keeps reading received bytes into a 16-entry ring buffer. Any byte that comes back on a data-write frame is kept as well.

Top module: `spi_uart_host_seq`

## Requirements
- R1: When idle, `spi_sck` and `spi_cs_n` are high. A frame pulls `spi_cs_n` low with `spi_sck` low and shifts 16 bits MSB first. `spi_mosi` changes only while `spi_sck` is low. `spi_miso` is sampled at the end of each high phase. At the end of the frame, `spi_cs_n` returns high while `spi_sck` is high.
- R2: `rate_sel` maps to a 4-bit baud code: 0→14, 1→13, 2→12, 3→11, 4→10, 5→9, 6→2, 7→1, 8→0. Every other value maps to 1.
- R3: After reset, the engine sends the configuration write word {2'b11, 10'b0, code}, then the read word 16'h4000. It compares response bits 13:0 with {10'b0, code}. On a mismatch it waits GAP_CYC cycles and repeats, for at most MAX_TRIES rounds, and then goes on to normal service. `tx_ready` stays low until then.
- R4: For each byte to send, the engine sends 16'h4000 frames until a response has bit 14 set. It then sends 16'h8000 | byte.
- R5: An input byte 8'h0A is sent as a write of 8'h0D followed by a write of 8'h0A. Each write is preceded by its own transmit-empty poll.
- R6: Received bytes leave the ring in arrival order. `rx_valid` is high exactly when the ring holds at least one byte. A cycle with `rx_valid` and `rx_ready` both high removes the oldest byte.
- R7: When no byte is being sent and the ring is not full, the engine sends read frames 16'h0000. If a response has bit 15 set, its bits 7:0 are stored and another read follows at once. Reading stops when bit 15 is clear or the ring is full.
- R8: If the response to a data-write frame has bit 15 set, its bits 7:0 are stored when the ring has space.
- R9: While the ring holds 16 bytes, no read frame is started and no SPI activity takes place.
- R10: `tx_ready` is high only between frames, with `spi_cs_n` high. Each `tx_valid`/`tx_ready` handshake takes exactly one byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | asynchronous active-low reset |
| rate_sel | input | 4 | requested line-rate index, mapped per R2 |
| tx_data | input | 8 | byte to transmit |
| tx_valid | input | 1 | tx_data is valid |
| tx_ready | output | 1 | engine accepts tx_data this cycle |
| rx_data | output | 8 | oldest received byte |
| rx_valid | output | 1 | a received byte is available |
| rx_ready | input | 1 | consumer takes rx_data |
| spi_sck | output | 1 | SPI clock |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_mosi | output | 1 | SPI data to the bridge |
| spi_miso | input | 1 | SPI data from the bridge |

## Verification
A frame lasts 1 + 32·HALF_CYC cycles. Chip select falls on the edge that follows the frame request. The frame's result acts on the sequencer one cycle after chip select rises. A pop shows on `rx_data` and `rx_valid` after the next clock edge.

The bench samples every output on the falling clock edge. It waits on `tx_ready` or on a cycle budget that covers several whole frames, never on a guessed cycle count. A bridge model records every frame word, and the frame order is checked against that record. The ring-full case is checked by confirming that the record does not grow over a window several frames long.

// File: rtl/suhs_pkg.sv
package suhs_pkg;

  typedef enum logic [2:0] {
    ST_CFG_WR,
    ST_CFG_RD,
    ST_GAP,
    ST_IDLE,
    ST_TX_POLL,
    ST_TX_WR,
    ST_RX_RD
  } seq_state_e;

  localparam logic [1:0] OP_WCFG = 2'b11;
  localparam logic [1:0] OP_RCFG = 2'b01;
  localparam logic [1:0] OP_WDAT = 2'b10;
  localparam logic [1:0] OP_RDAT = 2'b00;

  localparam logic [7:0] CHR_LF = 8'h0A;
  localparam logic [7:0] CHR_CR = 8'h0D;

  // rate index to bridge baud code; unknown indices fall back to code 1
  function automatic logic [3:0] baud_code(input logic [3:0] idx);
    logic [3:0] c;
    case (idx)
      4'd0:    c = 4'd14;
      4'd1:    c = 4'd13;
      4'd2:    c = 4'd12;
      4'd3:    c = 4'd11;
      4'd4:    c = 4'd10;
      4'd5:    c = 4'd9;
      4'd6:    c = 4'd2;
      4'd7:    c = 4'd1;
      4'd8:    c = 4'd0;
      default: c = 4'd1;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/suhs_spi_master.sv
module suhs_spi_master #(
  parameter int HALF_CYC = 25,
  parameter int FW       = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [FW-1:0] tx_word,
  output logic          busy,
  output logic          done,
  output logic [FW-1:0] rx_word,
  output logic          sck,
  output logic          cs_n,
  output logic          mosi,
  input  logic          miso
);
  localparam int TW = $clog2(HALF_CYC + 1);
  localparam int BW = $clog2(FW);
  localparam logic [TW-1:0] T_RELOAD = TW'(HALF_CYC - 1);
  localparam logic [BW-1:0] B_LAST   = BW'(FW - 1);

  logic          busy_q, busy_n;
  logic          ph_q, ph_n;
  logic [TW-1:0] tmr_q, tmr_n;
  logic [BW-1:0] bit_q, bit_n;
  logic [FW-1:0] txs_q, txs_n, rxs_q, rxs_n;
  logic          sck_q, sck_n, cs_q, cs_n_n, done_q, done_n;

  always_comb begin
    busy_n = busy_q;
    ph_n   = ph_q;
    tmr_n  = tmr_q;
    bit_n  = bit_q;
    txs_n  = txs_q;
    rxs_n  = rxs_q;
    sck_n  = sck_q;
    cs_n_n = cs_q;
    done_n = 1'b0;
    if (!busy_q) begin
      if (start) begin
        busy_n = 1'b1;
        cs_n_n = 1'b0;
        sck_n  = 1'b0;
        ph_n   = 1'b0;
        tmr_n  = T_RELOAD;
        bit_n  = '0;
        txs_n  = tx_word;
      end
    end else if (tmr_q != '0) begin
      tmr_n = tmr_q - 1'b1;
    end else if (!ph_q) begin
      sck_n = 1'b1;
      ph_n  = 1'b1;
      tmr_n = T_RELOAD;
    end else begin
      rxs_n = {rxs_q[FW-2:0], miso};
      if (bit_q == B_LAST) begin
        busy_n = 1'b0;
        sck_n  = 1'b1;
        cs_n_n = 1'b1;
        done_n = 1'b1;
      end else begin
        sck_n = 1'b0;
        ph_n  = 1'b0;
        tmr_n = T_RELOAD;
        bit_n = bit_q + 1'b1;
        txs_n = {txs_q[FW-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      ph_q   <= 1'b0;
      tmr_q  <= '0;
      bit_q  <= '0;
      txs_q  <= '0;
      rxs_q  <= '0;
      sck_q  <= 1'b1;
      cs_q   <= 1'b1;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_n;
      ph_q   <= ph_n;
      tmr_q  <= tmr_n;
      bit_q  <= bit_n;
      txs_q  <= txs_n;
      rxs_q  <= rxs_n;
      sck_q  <= sck_n;
      cs_q   <= cs_n_n;
      done_q <= done_n;
    end
  end

  assign busy    = busy_q;
  assign done    = done_q;
  assign rx_word = rxs_q;
  assign sck     = sck_q;
  assign cs_n    = cs_q;
  assign mosi    = txs_q[FW-1];

  // R1: chip select releases only with the clock parked high
  assert_cs_release_sck_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> sck);
  // R1: data out holds while the clock is high inside a frame
  assert_mosi_stable_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (sck && $past(sck) && !cs_n && !$past(cs_n)) |-> $stable(mosi));

endmodule

// File: rtl/suhs_rx_ring.sv
module suhs_rx_ring #(
  parameter int DEPTH = 16,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] rd_data,
  output logic          nonempty,
  output logic          full
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] C_FULL = CW'(DEPTH);

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wp_q, wp_n, rp_q, rp_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          do_push, do_pop;

  assign do_push = push && (cnt_q != C_FULL);
  assign do_pop  = pop && (cnt_q != '0);

  always_comb begin
    wp_n  = do_push ? wp_q + 1'b1 : wp_q;
    rp_n  = do_pop ? rp_q + 1'b1 : rp_q;
    cnt_n = cnt_q;
    if (do_push && !do_pop) cnt_n = cnt_q + 1'b1;
    else if (!do_push && do_pop) cnt_n = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_n;
      rp_q  <= rp_n;
      cnt_q <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem_q[wp_q] <= push_data;
  end

  assign rd_data  = mem_q[rp_q];
  assign nonempty = (cnt_q != '0);
  assign full     = (cnt_q == C_FULL);

  // R6: occupancy never exceeds the ring size
  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= C_FULL);
  // R6: a lone pop lowers the occupancy by one
  assert_pop_lowers_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && nonempty && !push) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/spi_uart_host_seq.sv
module spi_uart_host_seq
  import suhs_pkg::*;
#(
  parameter int HALF_CYC  = 25,
  parameter int GAP_CYC   = 5000,
  parameter int MAX_TRIES = 100,
  parameter int DEPTH     = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] rate_sel,
  input  logic [7:0] tx_data,
  input  logic       tx_valid,
  output logic       tx_ready,
  output logic [7:0] rx_data,
  output logic       rx_valid,
  input  logic       rx_ready,
  output logic       spi_sck,
  output logic       spi_cs_n,
  output logic       spi_mosi,
  input  logic       spi_miso
);
  localparam int TRW = $clog2(MAX_TRIES + 1);
  localparam int GW  = $clog2(GAP_CYC + 1);
  localparam logic [TRW-1:0] TRY_LAST = TRW'(MAX_TRIES - 1);
  localparam logic [GW-1:0]  GAP_LAST = GW'(GAP_CYC - 1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i = rsync_q[1];

  seq_state_e     st_q, st_n;
  logic           infl_q, infl_n;
  logic [TRW-1:0] tries_q, tries_n;
  logic [GW-1:0]  gap_q, gap_n;
  logic [7:0]     hold_q, hold_n;
  logic           cr_q, cr_n;

  logic        spi_start, spi_busy, spi_done;
  logic [15:0] spi_word, spi_resp;
  logic        rb_push, rb_pop, rb_full, rb_nonempty;
  logic [3:0]  code;

  assign code = baud_code(rate_sel);

  always_comb begin
    st_n      = st_q;
    infl_n    = infl_q;
    tries_n   = tries_q;
    gap_n     = gap_q;
    hold_n    = hold_q;
    cr_n      = cr_q;
    spi_start = 1'b0;
    spi_word  = 16'h0000;
    rb_push   = 1'b0;
    tx_ready  = 1'b0;
    case (st_q)
      ST_CFG_WR: begin
        spi_word = {OP_WCFG, 10'b0, code};
        if (!infl_q) begin
          spi_start = 1'b1;
          infl_n    = 1'b1;
        end else if (spi_done) begin
          infl_n = 1'b0;
          st_n   = ST_CFG_RD;
        end
      end
      ST_CFG_RD: begin
        spi_word = {OP_RCFG, 14'b0};
        if (!infl_q) begin
          spi_start = 1'b1;
          infl_n    = 1'b1;
        end else if (spi_done) begin
          infl_n = 1'b0;
          if (spi_resp[13:0] == {10'b0, code} || tries_q == TRY_LAST) begin
            st_n = ST_IDLE;
          end else begin
            tries_n = tries_q + 1'b1;
            gap_n   = '0;
            st_n    = ST_GAP;
          end
        end
      end
      ST_GAP: begin
        gap_n = gap_q + 1'b1;
        if (gap_q == GAP_LAST) st_n = ST_CFG_WR;
      end
      ST_IDLE: begin
        tx_ready = 1'b1;
        if (tx_valid) begin
          hold_n = tx_data;
          cr_n   = (tx_data == CHR_LF);
          st_n   = ST_TX_POLL;
        end else if (!rb_full) begin
          st_n = ST_RX_RD;
        end
      end
      ST_TX_POLL: begin
        spi_word = {OP_RCFG, 14'b0};
        if (!infl_q) begin
          spi_start = 1'b1;
          infl_n    = 1'b1;
        end else if (spi_done) begin
          infl_n = 1'b0;
          if (spi_resp[14]) st_n = ST_TX_WR;
        end
      end
      ST_TX_WR: begin
        spi_word = {OP_WDAT, 6'b0, (cr_q ? CHR_CR : hold_q)};
        if (!infl_q) begin
          spi_start = 1'b1;
          infl_n    = 1'b1;
        end else if (spi_done) begin
          infl_n  = 1'b0;
          rb_push = spi_resp[15];
          if (cr_q) begin
            cr_n = 1'b0;
            st_n = ST_TX_POLL;
          end else begin
            st_n = ST_IDLE;
          end
        end
      end
      ST_RX_RD: begin
        spi_word = {OP_RDAT, 14'b0};
        if (!infl_q) begin
          if (rb_full) begin
            st_n = ST_IDLE;
          end else begin
            spi_start = 1'b1;
            infl_n    = 1'b1;
          end
        end else if (spi_done) begin
          infl_n  = 1'b0;
          rb_push = spi_resp[15];
          if (!spi_resp[15]) st_n = ST_IDLE;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      st_q    <= ST_CFG_WR;
      infl_q  <= 1'b0;
      tries_q <= '0;
      gap_q   <= '0;
      hold_q  <= '0;
      cr_q    <= 1'b0;
    end else begin
      st_q    <= st_n;
      infl_q  <= infl_n;
      tries_q <= tries_n;
      gap_q   <= gap_n;
      hold_q  <= hold_n;
      cr_q    <= cr_n;
    end
  end

  suhs_spi_master #(.HALF_CYC(HALF_CYC), .FW(16)) u_spi (
    .clk     (clk),
    .rst_n   (rst_i),
    .start   (spi_start),
    .tx_word (spi_word),
    .busy    (spi_busy),
    .done    (spi_done),
    .rx_word (spi_resp),
    .sck     (spi_sck),
    .cs_n    (spi_cs_n),
    .mosi    (spi_mosi),
    .miso    (spi_miso)
  );

  assign rb_pop = rx_ready;

  suhs_rx_ring #(.DEPTH(DEPTH), .DW(8)) u_ring (
    .clk       (clk),
    .rst_n     (rst_i),
    .push      (rb_push),
    .push_data (spi_resp[7:0]),
    .pop       (rb_pop),
    .rd_data   (rx_data),
    .nonempty  (rb_nonempty),
    .full      (rb_full)
  );

  assign rx_valid = rb_nonempty;

  // R9: no data-read frame is launched into a full ring
  assert_no_read_when_full_R9: assert property (@(posedge clk) disable iff (!rst_i)
    (spi_start && spi_word[15:14] == OP_RDAT) |-> !rb_full);
  // R10: byte intake only happens with the link quiet
  assert_ready_link_quiet_R10: assert property (@(posedge clk) disable iff (!rst_i)
    tx_ready |-> (spi_cs_n && !spi_busy));
  // R1: a new frame is requested only while the master is idle
  assert_start_when_idle_R1: assert property (@(posedge clk) disable iff (!rst_i)
    spi_start |-> !spi_busy);

endmodule

// File: tb/spi_uart_host_seq_tb_top.sv
module spi_uart_host_seq_tb_top;
  localparam int HALF = 2;
  localparam int GAP  = 20;
  localparam int TRY  = 4;

  logic       clk, rst_n;
  logic [3:0] rate_sel;
  logic [7:0] tx_data, rx_data;
  logic       tx_valid, tx_ready, rx_valid, rx_ready;
  logic       spi_sck, spi_cs_n, spi_mosi, spi_miso;

  int total, bad, cyc;

  spi_uart_host_seq #(.HALF_CYC(HALF), .GAP_CYC(GAP), .MAX_TRIES(TRY), .DEPTH(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      bad   = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: act=%0d exp<=150000 cycles", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // ---------------- bridge model ----------------
  logic [15:0] flog [8192];
  int          nfr;
  logic [13:0] cfg;
  int          corrupt, tbusy, bitn;
  logic [7:0]  q [64];
  int          q_wr, q_rd;
  logic        hide_rx, rx_now;
  logic [15:0] cmd, resp;

  initial begin
    bitn = 0; nfr = 0; cfg = '0; corrupt = 0; tbusy = 0;
    q_wr = 0; q_rd = 0; hide_rx = 1'b0; rx_now = 1'b0;
    cmd = '0; resp = '0; spi_miso = 1'b0;
  end

  always @(negedge spi_cs_n) begin
    bitn   = 0;
    cmd    = '0;
    rx_now = (q_wr > q_rd) && !hide_rx;
    resp   = {rx_now, (tbusy == 0), 14'b0};
    spi_miso = resp[15];
  end

  always @(posedge spi_sck) begin
    if (!spi_cs_n) begin
      cmd  = {cmd[14:0], spi_mosi};
      bitn = bitn + 1;
      if (bitn == 1 && hide_rx && (q_wr > q_rd) && spi_mosi) begin
        rx_now   = 1'b1;
        resp[15] = 1'b1;
        spi_miso = 1'b1;
      end
      if (bitn == 2) begin
        if (cmd[1:0] == 2'b01) resp[13:0] = cfg;
        else if (rx_now) resp[13:0] = {6'b0, q[q_rd]};
      end
    end
  end

  always @(negedge spi_sck) begin
    if (!spi_cs_n && bitn > 0 && bitn < 16) spi_miso = resp[15-bitn];
  end

  always @(posedge spi_cs_n) begin
    if (nfr < 8192) flog[nfr] = cmd;
    nfr = nfr + 1;
    if (cmd[15:14] == 2'b11) begin
      cfg = (corrupt > 0) ? (cmd[13:0] ^ 14'h1) : cmd[13:0];
      if (corrupt > 0) corrupt = corrupt - 1;
    end
    if (cmd[15:14] == 2'b01 && tbusy > 0) tbusy = tbusy - 1;
    if (rx_now && !cmd[14]) q_rd = q_rd + 1;
  end

  // ---------------- helpers ----------------
  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total = total + 1;
    if (!ok) begin
      bad = bad + 1;
      $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_ready();
    int t = 0;
    @(negedge clk);
    while (!tx_ready && t < 20000) begin
      @(negedge clk);
      t++;
    end
  endtask

  task automatic do_reset(input logic [3:0] rs, input int corr);
    rst_n = 1'b0;
    rate_sel = rs;
    corrupt = corr;
    tbusy = 0;
    repeat (3) @(negedge clk);
    nfr = 0;
    rst_n = 1'b1;
  endtask

  task automatic send(input logic [7:0] b, output int idx);
    wait_ready();
    tx_data  = b;
    tx_valid = 1'b1;
    idx = nfr;
    @(posedge clk);
    #1 tx_valid = 1'b0;
  endtask

  task automatic pop_chk(input logic [7:0] exp, input string tag);
    @(negedge clk);
    chk(rx_valid == 1'b1, tag, rx_valid, 1);
    chk(rx_data == exp, tag, rx_data, exp);
    rx_ready = 1'b1;
    @(posedge clk);
    #1 rx_ready = 1'b0;
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(spi_cs_n == 1'b1, "R1 idle cs_n", spi_cs_n, 1);
    chk(spi_sck == 1'b1, "R1 idle sck", spi_sck, 1);
    chk(tx_ready == 1'b0, "R3 tx_ready low in reset", tx_ready, 0);
    chk(rx_valid == 1'b0, "R6 rx_valid empty", rx_valid, 0);
  endtask

  task automatic t_init_retry();
    do_reset(4'd7, 1);
    repeat (5) @(negedge clk);
    chk(tx_ready == 1'b0, "R3 tx_ready low during init", tx_ready, 0);
    wait_ready();
    chk(flog[0] == 16'hC001, "R3 first cfg write", flog[0], 16'hC001);
    chk(flog[1] == 16'h4000, "R3 cfg readback", flog[1], 16'h4000);
    chk(flog[2] == 16'hC001, "R3 retry write", flog[2], 16'hC001);
    chk(flog[3] == 16'h4000, "R3 retry readback", flog[3], 16'h4000);
  endtask

  task automatic t_init_exhaust();
    do_reset(4'd3, 99);
    wait_ready();
    repeat (200) @(negedge clk);
    for (int i = 0; i < 2*TRY; i++) begin
      logic [15:0] e = (i % 2 == 0) ? 16'hC00B : 16'h4000;
      chk(flog[i] == e, "R3 bounded retries", flog[i], e);
    end
    chk(flog[2*TRY] == 16'h0000, "R3 proceeds after limit", flog[2*TRY], 0);
    corrupt = 0;
  endtask

  task automatic t_rates();
    logic [3:0] exp [4] = '{4'd14, 4'd2, 4'd0, 4'd1};
    logic [3:0] sel [4] = '{4'd0, 4'd6, 4'd8, 4'd13};
    for (int k = 0; k < 4; k++) begin
      do_reset(sel[k], 0);
      wait_ready();
      chk(flog[0] == {2'b11, 10'b0, exp[k]}, "R2 baud code map", flog[0], {2'b11, 10'b0, exp[k]});
    end
  endtask

  task automatic t_tx_poll();
    int idx;
    tbusy = 2;
    send(8'h41, idx);
    wait_ready();
    chk(flog[idx] == 16'h4000 && flog[idx+1] == 16'h4000 && flog[idx+2] == 16'h4000,
        "R4 polls until empty", flog[idx+2], 16'h4000);
    chk(flog[idx+3] == 16'h8041, "R4 data write", flog[idx+3], 16'h8041);
  endtask

  task automatic t_lf();
    int idx;
    tbusy = 0;
    send(8'h0A, idx);
    wait_ready();
    chk(flog[idx] == 16'h4000, "R5 poll before CR", flog[idx], 16'h4000);
    chk(flog[idx+1] == 16'h800D, "R5 CR first", flog[idx+1], 16'h800D);
    chk(flog[idx+2] == 16'h4000, "R5 poll before LF", flog[idx+2], 16'h4000);
    chk(flog[idx+3] == 16'h800A, "R5 LF second", flog[idx+3], 16'h800A);
    chk(nfr - idx >= 4, "R10 one byte per handshake", nfr - idx, 4);
  endtask

  task automatic t_drain();
    q[q_wr] = 8'h11; q_wr++;
    q[q_wr] = 8'h22; q_wr++;
    q[q_wr] = 8'h33; q_wr++;
    repeat (600) @(negedge clk);
    chk(q_rd == q_wr, "R7 bridge drained", q_rd, q_wr);
    pop_chk(8'h11, "R6 R7 order 0");
    pop_chk(8'h22, "R6 R7 order 1");
    pop_chk(8'h33, "R6 R7 order 2");
    @(negedge clk);
    chk(rx_valid == 1'b0, "R6 empty after pops", rx_valid, 0);
  endtask

  task automatic t_write_capture();
    int idx;
    hide_rx = 1'b1;
    q[q_wr] = 8'h5A; q_wr++;
    send(8'h42, idx);
    wait_ready();
    chk(flog[idx+1] == 16'h8042, "R8 write frame", flog[idx+1], 16'h8042);
    hide_rx = 1'b0;
    pop_chk(8'h5A, "R8 byte captured on write");
  endtask

  task automatic t_full();
    int idx;
    for (int i = 0; i < 18; i++) begin
      q[q_wr] = 8'(8'h80 + i);
      q_wr++;
    end
    repeat (2000) @(negedge clk);
    idx = nfr;
    repeat (600) @(negedge clk);
    chk(nfr == idx, "R9 no frames while full", nfr, idx);
    chk(q_wr - q_rd == 2, "R9 bridge keeps overflow", q_wr - q_rd, 2);
    for (int i = 0; i < 16; i++) pop_chk(8'(8'h80 + i), "R6 R9 full ring order");
    repeat (600) @(negedge clk);
    pop_chk(8'h90, "R7 resumes after space");
    pop_chk(8'h91, "R7 resumes after space");
  endtask

  initial begin
    total = 0; bad = 0; cyc = 0;
    rst_n = 1'b0; rate_sel = 4'd7;
    tx_data = '0; tx_valid = 1'b0; rx_ready = 1'b0;
    t_reset();
    t_init_retry();
    t_init_exhaust();
    t_rates();
    do_reset(4'd7, 0);
    wait_ready();
    t_tx_poll();
    t_lf();
    t_drain();
    t_write_capture();
    t_full();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule